// File: doc/BRIEF.md
# Write-Protected System Clock Prescaler

This block produces a clock-enable that divides a master clock by a power of two chosen at run time. The divide select lives in an 8-bit control register. It is guarded so that a single stray write cannot change it. Software first writes an unlock pattern, which opens a short window. A second write made inside that window loads the new divide select. If no such write arrives, the window closes by itself. The synchronous logic downstream uses the enable output as its tick, so a new factor reaches everything derived from it.

A strap input picks the divide select loaded at reset: either no division, or division by eight for a master clock that is too fast at power-up. The unlock logic is a two-state machine:

- `PS_LOCKED`: the divide select is protected.
- `PS_OPEN`: the change window is running.

It moves between them on four named transitions:

- `T_ARM`: from `PS_LOCKED` to `PS_OPEN`, on an exact unlock pattern.
- `T_COMMIT`: from `PS_OPEN` to `PS_LOCKED`, on a select write.
- `T_EXPIRE`: from `PS_OPEN` to `PS_LOCKED`, when the window runs out.
- `T_HOLD`: no change of state.

Top module: `sysclk_prescaler`

## Requirements
- R1: While `rst_n` is low, the unlock status is 0. The divide select is 0 when `div8_strap` is 0 and 3 when `div8_strap` is 1.
- R2: Only a write of exactly 8'h80 (bit 7 = 1, bits 6..0 = 0) while locked opens the window (`T_ARM`). Any other write while locked leaves the status at 0.
- R3: After the arming write, the status reads 1 for exactly four cycles and then returns to 0 (`T_EXPIRE`), provided no select write arrives.
- R4: Writing 8'h80 again while the window is open neither restarts the four-cycle window nor closes it.
- R5: A write with bit 7 = 0 while the window is open does two things at that clock edge. It loads data bits 3..0 into the divide select, ignoring bits 6..4. It also closes the window (`T_COMMIT`).
- R6: A write with bit 7 = 0 while locked leaves the divide select unchanged.
- R7: Divide select n gives a factor of 2^n for n = 0..8. Values 9..15 give a factor of 256.
- R8: `clk_en` is high for one cycle in every factor cycles. When the factor is 1 it is high every cycle.
- R9: An accepted select write restarts the divider. The first `clk_en` pulse then comes in the cycle that is the factor-th cycle after the write edge.
- R10: `rd_data` shows the unlock status in bit 7, zeros in bits 6..4 and the divide select in bits 3..0.
- R11: A write with bit 7 = 1 and a non-zero bits 6..0 while the window is open leaves the window and the divide select unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div8_strap | input | 1 | Picks the divide select at reset: 1 gives 3, 0 gives 0 |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read view |
| unlock_status | output | 1 | High while the change window is open |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
Directed sequences cover the arming pattern against near-miss patterns, which separates an exact pattern decode from a bit-7-only decode. They also cover a repeated arm inside the window, which shows whether the timeout restarts, and select writes at the last cycle of the window and one cycle after it, which pin down the window length. Both strap settings are applied, and select values of 0, 8 and a reserved value are tried, which separates the pulse-every-cycle case, the widest legal factor and the clamping of reserved codes. A seeded random mix of arming, select and junk writes then runs against a cycle-accurate bench model of status, select and pulse position.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned MAX_EXP = 8;
    localparam int unsigned WIN_LEN = 4;

    typedef enum logic [0:0] {
        PS_LOCKED = 1'b0,
        PS_OPEN   = 1'b1
    } unlock_state_e;

    typedef enum logic [1:0] {
        T_HOLD   = 2'd0,
        T_ARM    = 2'd1,
        T_COMMIT = 2'd2,
        T_EXPIRE = 2'd3
    } unlock_trans_e;

    // Counter mask for a divide select: (2^min(sel,max_exp)) - 1
    function automatic logic [MAX_EXP-1:0] sel_to_mask(input logic [SEL_W-1:0] sel);
        logic [MAX_EXP:0] full;
        int unsigned      e;
        e    = (int'(sel) > int'(MAX_EXP)) ? MAX_EXP : int'(sel);
        full = ({{MAX_EXP{1'b0}}, 1'b1} << e) - 1'b1;
        return full[MAX_EXP-1:0];
    endfunction

endpackage

// File: rtl/presc_unlock_fsm.sv
module presc_unlock_fsm
    import presc_pkg::*;
#(
    parameter int unsigned DATA_W  = REG_W,
    parameter int unsigned WINDOW  = WIN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              open_o,
    output logic              commit_o
);

    localparam int unsigned CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW - 1);
    localparam logic [DATA_W-1:0] ARM_PATTERN = {1'b1, {(DATA_W-1){1'b0}}};

    unlock_state_e state_q, state_d;
    unlock_trans_e trans;
    logic [CNT_W-1:0] left_q, left_d;

    logic arm_hit;
    logic sel_hit;

    assign arm_hit = wr_en && (wr_data == ARM_PATTERN);
    assign sel_hit = wr_en && !wr_data[DATA_W-1];

    // transition selection
    always_comb begin
        trans = T_HOLD;
        unique case (state_q)
            PS_LOCKED: begin
                if (arm_hit) trans = T_ARM;
            end
            PS_OPEN: begin
                if (sel_hit)              trans = T_COMMIT;
                else if (left_q == '0)    trans = T_EXPIRE;
            end
            default: trans = T_HOLD;
        endcase
    end

    // next-state and window counter
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (trans)
            T_ARM: begin
                state_d = PS_OPEN;
                left_d  = CNT_LOAD;
            end
            T_COMMIT, T_EXPIRE: begin
                state_d = PS_LOCKED;
                left_d  = '0;
            end
            T_HOLD: begin
                if (state_q == PS_OPEN) left_d = left_q - 1'b1;
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_LOCKED;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        open_o   = (state_q == PS_OPEN);
        commit_o = (trans == T_COMMIT);
    end

    // R3: the window never outlives its last count
    a_r3_window_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPEN && left_q == '0) |=> (state_q == PS_LOCKED));

    // R2: opening only follows the exact pattern
    a_r2_arm_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(wr_en && wr_data == ARM_PATTERN));

    // R4: a repeated arm does not reload the window
    a_r4_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPEN && arm_hit && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

    // R5: a commit always closes the window
    a_r5_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !open_o);

endmodule

// File: rtl/presc_sel_reg.sv
module presc_sel_reg
    import presc_pkg::*;
#(
    parameter int unsigned FIELD_W = SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div8_strap,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] new_sel_i,
    output logic [FIELD_W-1:0] sel_o
);

    localparam logic [FIELD_W-1:0] SEL_RST_SLOW = FIELD_W'(3);
    localparam logic [FIELD_W-1:0] SEL_RST_FAST = '0;

    logic [FIELD_W-1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= div8_strap ? SEL_RST_SLOW : SEL_RST_FAST;
        end else if (load_i) begin
            sel_q <= new_sel_i;
        end
    end

    assign sel_o = sel_q;

    // R6: without a commit the field holds
    a_r6_sel_protected: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sel_q));

    // R5: a commit takes the written field
    a_r5_sel_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sel_q == $past(new_sel_i)));

endmodule

// File: rtl/presc_divider.sv
module presc_divider
    import presc_pkg::*;
#(
    parameter int unsigned FIELD_W = SEL_W,
    parameter int unsigned EXP_MAX = MAX_EXP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] sel_i,
    input  logic               restart_i,
    output logic               tick_o
);

    localparam int unsigned CNT_W = EXP_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             wrap;

    assign mask = sel_to_mask(sel_i);
    assign wrap = (cnt_q == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = wrap;

    // R9: an accepted select restarts the count
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

    // R8: a pulse is a single cycle whenever the factor exceeds one
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && mask != '0 && !restart_i) |=> !tick_o);

    // R7: the count never passes its mask
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && $stable(sel_i)) |=> (cnt_q <= mask));

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
    import presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div8_strap,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             unlock_status,
    output logic             clk_en
);

    localparam int unsigned PAD_W = REG_W - SEL_W - 1;

    logic             open_w;
    logic             commit_w;
    logic [SEL_W-1:0] sel_w;

    presc_unlock_fsm #(
        .DATA_W (REG_W),
        .WINDOW (WIN_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .open_o   (open_w),
        .commit_o (commit_w)
    );

    presc_sel_reg #(
        .FIELD_W (SEL_W)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .div8_strap (div8_strap),
        .load_i     (commit_w),
        .new_sel_i  (wr_data[SEL_W-1:0]),
        .sel_o      (sel_w)
    );

    presc_divider #(
        .FIELD_W (SEL_W),
        .EXP_MAX (MAX_EXP)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_w),
        .restart_i (commit_w),
        .tick_o    (clk_en)
    );

    assign unlock_status = open_w;
    assign rd_data       = {open_w, {PAD_W{1'b0}}, sel_w};

    // R10: reserved read bits stay zero
    a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-2:SEL_W] == '0);

    // R10: the status port matches the read view
    a_r10_status_view: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1] == unlock_status);

endmodule

// File: tb/sysclk_prescaler_tb.sv
module sysclk_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div8_strap = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       unlock_status;
    logic       clk_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    bit       m_open;
    int       m_left;
    bit [3:0] m_sel;
    int       m_div;

    sysclk_prescaler u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .div8_strap    (div8_strap),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .unlock_status (unlock_status),
        .clk_en        (clk_en)
    );

    always #10 clk = ~clk;

    function automatic int factor_of(input bit [3:0] s);
        int e;
        e = (s > 4'd8) ? 8 : int'(s);
        return 1 << e;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, actual, expected, cycles);
        end
    endtask

    task automatic check_all();
        check("R10 rd_data", int'(rd_data), int'({m_open, 3'b000, m_sel}));
        check("R3 status", int'(unlock_status), int'(m_open));
        check("R8 clk_en", int'(clk_en), int'(m_div == factor_of(m_sel) - 1));
    endtask

    // called at negedge: check, drive, advance model over next posedge
    task automatic step(input bit w, input logic [7:0] d);
        bit acc;
        int f;
        check_all();
        wr_en   = w;
        wr_data = d;
        @(posedge clk);
        f   = factor_of(m_sel);
        acc = m_open && w && !d[7];
        if (!m_open) begin
            if (w && d == 8'h80) begin
                m_open = 1'b1;
                m_left = 3;
            end
        end else if (acc) begin
            m_open = 1'b0;
            m_sel  = d[3:0];
        end else if (m_left == 0) begin
            m_open = 1'b0;
        end else begin
            m_left--;
        end
        if (acc) m_div = 0;
        else     m_div = (m_div == f - 1) ? 0 : m_div + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00);
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        div8_strap = strap;
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        // R1: values during reset
        check("R1 status in reset", int'(unlock_status), 0);
        check("R1 select in reset", int'(rd_data[3:0]), strap ? 3 : 0);
        @(negedge clk);
        rst_n  = 1'b1;
        m_open = 1'b0;
        m_left = 0;
        m_sel  = strap ? 4'd3 : 4'd0;
        m_div  = 0;
    endtask

    task automatic change_sel(input logic [3:0] s);
        step(1'b1, 8'h80);
        step(1'b1, {4'b0000, s});
    endtask

    initial begin
        int gap;
        logic [7:0] d;
        int r;
        void'($urandom(32'h5EED_0417));

        // R1 both strap settings
        do_reset(1'b1);
        check("R1 strap=1 select", int'(rd_data), 8'h03);
        idle(20);
        do_reset(1'b0);
        check("R1 strap=0 select", int'(rd_data), 8'h00);
        check("R8 factor 1 continuous", int'(clk_en), 1);
        idle(5);

        // R2 near-miss patterns do not arm
        step(1'b1, 8'h81);
        check("R2 0x81 does not arm", int'(unlock_status), 0);
        step(1'b1, 8'hC0);
        check("R2 0xC0 does not arm", int'(unlock_status), 0);
        step(1'b1, 8'h90);
        check("R2 0x90 does not arm", int'(unlock_status), 0);
        step(1'b0, 8'h80);
        check("R2 no strobe does not arm", int'(unlock_status), 0);

        // R6 select write while locked ignored
        step(1'b1, 8'h05);
        check("R6 locked select write ignored", int'(rd_data[3:0]), 0);

        // R3 window lasts exactly four cycles
        step(1'b1, 8'h80);
        for (int i = 0; i < 4; i++) begin
            check("R3 window open", int'(unlock_status), 1);
            step(1'b0, 8'h00);
        end
        check("R3 window expired", int'(unlock_status), 0);
        step(1'b1, 8'h02);
        check("R3 late select ignored", int'(rd_data[3:0]), 0);

        // R4 re-arm inside window does not extend
        step(1'b1, 8'h80);
        step(1'b1, 8'h80);
        check("R4 re-arm keeps window", int'(unlock_status), 1);
        step(1'b1, 8'h80);
        step(1'b0, 8'h00);
        step(1'b1, 8'h80);
        check("R4 window not restarted", int'(unlock_status), 0);

        // R11 junk with bit 7 set inside window
        step(1'b1, 8'h80);
        step(1'b1, 8'hFF);
        check("R11 junk keeps window", int'(unlock_status), 1);
        check("R11 junk keeps select", int'(rd_data[3:0]), 0);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        // R5 select on last window cycle, reserved bits ignored
        check("R5 still open on last cycle", int'(unlock_status), 1);
        step(1'b1, 8'h72);
        check("R5 select loaded", int'(rd_data), 8'h02);
        check("R5 enable cleared", int'(unlock_status), 0);

        // R9 first pulse after restart at cycle 4 (factor 4)
        check("R9 no pulse right after change", int'(clk_en), 0);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        check("R9 no pulse at cycle 3", int'(clk_en), 0);
        step(1'b0, 8'h00);
        check("R9 pulse at factor cycle", int'(clk_en), 1);
        idle(10);

        // R7 factor 256 and reserved clamp
        change_sel(4'd8);
        gap = 0;
        while (clk_en !== 1'b1 && gap < 400) begin step(1'b0, 8'h00); gap++; end
        check("R7 factor 256 first pulse", gap, 255);
        change_sel(4'd13);
        check("R7 reserved code stored", int'(rd_data[3:0]), 13);
        gap = 0;
        while (clk_en !== 1'b1 && gap < 400) begin step(1'b0, 8'h00); gap++; end
        check("R7 reserved code gives 256", gap, 255);
        step(1'b0, 8'h00);
        gap = 1;
        while (clk_en !== 1'b1 && gap < 400) begin step(1'b0, 8'h00); gap++; end
        check("R8 period 256", gap, 256);

        // back to factor 1: continuous
        change_sel(4'd0);
        for (int i = 0; i < 3; i++) begin
            check("R8 factor 1 every cycle", int'(clk_en), 1);
            step(1'b0, 8'h00);
        end

        // random mix
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom_range(0, 9));
            if (r < 3)      d = 8'h80;
            else if (r < 6) d = {1'b0, 3'($urandom), 4'($urandom_range(0, 5))};
            else            d = 8'($urandom);
            step(($urandom_range(0, 2) != 0), d);
        end
        check_all();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule